// File: doc/BRIEF.md
# Performance Counter Global Control and Overflow Status

This block is the shared control plane that sits beside a bank of general-purpose and fixed-function event counters. It keeps the per-counter global enable bits and the packed control fields of the fixed counters. It combines them with the local enables supplied by each general-purpose counter's selector and produces the run signals the counters obey. Overflow pulses arriving from the counters are latched into a sticky status register. Software clears those bits by writing ones to a separate clear register. An overflow whose interrupt enable is set produces a single-cycle interrupt request toward the interrupt controller.

The general-purpose and fixed counters share one 64-bit index space. General-purpose counter n occupies bit n and fixed counter k occupies bit 32+k, in the enable, status and clear registers alike. Software reaches the four registers through a plain address / write-enable / read-data port. Reads are combinational and writes take effect at the clock edge.

Top module: `pmu_global_ctl`

## Requirements
- R1: After reset every register reads zero, `irq` is low, and all run, OS-count and user-count outputs are low.
- R2: Address 1 is the global enable register. Bit n (n < NUM_GP) belongs to general-purpose counter n and bit 32+k (k < NUM_FIX) belongs to fixed counter k. Bits of counters that do not exist read as zero and ignore writes.
- R3: Address 0 is the fixed-counter control register. Fixed counter k owns bits 4k+3:4k, and bits above 4·NUM_FIX read as zero. Within a field, bit 0 enables OS-mode counting, bit 1 enables user-mode counting, and bit 3 enables the overflow interrupt. `fix_os_cnt[k]` is field bit 0 gated by the counter's global enable bit, and `fix_usr_cnt[k]` is field bit 1 gated the same way.
- R4: `gp_run[n]` is high exactly when global enable bit n and `gp_local_en[n]` are both set. `fix_run[k]` is high exactly when global enable bit 32+k is set and bits 1:0 of field k are nonzero.
- R5: An overflow pulse on a counter sets that counter's bit in the status register (address 2) at the next clock edge. The bit then stays set until it is cleared.
- R6: Writing to address 3 clears each status bit whose data bit is 1, from the next cycle on. Zero data bits leave the status unchanged, and address 3 always reads zero.
- R7: When an overflow pulse and a clear arrive for the same bit in the same cycle, the bit remains set.
- R8: `irq` is high for exactly one cycle, the cycle after one or more overflow pulses whose interrupt enable was set. The interrupt enable is `gp_int_en[n]` for general-purpose counters and field bit 3 for fixed counters. An overflow with its interrupt enable clear sets status but leaves `irq` low.
- R9: Writes to address 2 have no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 fixed control, 1 global enable, 2 status, 3 overflow clear |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, combinational |
| gp_local_en | input | NUM_GP | Selector enable bit of each general-purpose counter |
| gp_int_en | input | NUM_GP | Selector interrupt enable of each general-purpose counter |
| gp_ovf | input | NUM_GP | Overflow pulse from each general-purpose counter |
| fix_ovf | input | NUM_FIX | Overflow pulse from each fixed counter |
| gp_run | output | NUM_GP | Run enable to each general-purpose counter |
| fix_run | output | NUM_FIX | Run enable to each fixed counter |
| fix_os_cnt | output | NUM_FIX | Count-in-OS-mode enable to each fixed counter |
| fix_usr_cnt | output | NUM_FIX | Count-in-user-mode enable to each fixed counter |
| irq | output | 1 | Counter-overflow interrupt request pulse |

## Verification
A wrong status bit is visible on the read port in the cycle after the overflow or clear that caused it, so every status read is compared with a model updated edge by edge. A wrong enable or control field shows up combinationally on the run outputs and in the readback of addresses 0 and 1. A wrong interrupt-enable path shows up as a missing or extra `irq` pulse exactly one cycle after the overflow. The random phase mixes writes, clears and overflow pulses with random interrupt enables. Directed cases then cover the unimplemented bits, the collision of clear with overflow, and writes to the status address.

// File: rtl/pmu_gc_pkg.sv
package pmu_gc_pkg;
  localparam int REG_W    = 64;
  localparam int FIX_BASE = 32;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] A_FIX_CTL = 2'd0;
  localparam logic [ADDR_W-1:0] A_GLB_EN  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STATUS  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLEAR   = 2'd3;

  // Bits of the shared index space backed by a real counter.
  function automatic logic [REG_W-1:0] impl_mask(input int ng, input int nf);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < REG_W; i++) begin
      if (i < ng) m[i] = 1'b1;
      if (i >= FIX_BASE && i < FIX_BASE + nf) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pmu_gc_regs.sv
module pmu_gc_regs
  import pmu_gc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  localparam int FCTL_W = 4 * NUM_FIX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [FCTL_W-1:0] fctl_q,
  output logic [REG_W-1:0]  gen_q,
  output logic [REG_W-1:0]  clr_vec
);
  localparam logic [REG_W-1:0] MASK = impl_mask(NUM_GP, NUM_FIX);

  logic              fctl_ld;
  logic              gen_ld;
  logic [FCTL_W-1:0] fctl_d;
  logic [REG_W-1:0]  gen_d;

  always_comb begin
    fctl_ld = reg_we && (reg_addr == A_FIX_CTL);
    gen_ld  = reg_we && (reg_addr == A_GLB_EN);
    fctl_d  = reg_wdata[FCTL_W-1:0];
    gen_d   = reg_wdata & MASK;
    clr_vec = (reg_we && (reg_addr == A_CLEAR)) ? (reg_wdata & MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fctl_q <= '0;
    else if (fctl_ld) fctl_q <= fctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gen_q <= '0;
    else if (gen_ld) gen_q <= gen_d;
  end
endmodule

// File: rtl/pmu_gc_gate.sv
module pmu_gc_gate
  import pmu_gc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  localparam int FCTL_W = 4 * NUM_FIX
) (
  input  logic [REG_W-1:0]   gen_q,
  input  logic [FCTL_W-1:0]  fctl_q,
  input  logic [NUM_GP-1:0]  gp_local_en,
  input  logic [NUM_GP-1:0]  gp_int_en,
  input  logic [NUM_GP-1:0]  gp_ovf,
  input  logic [NUM_FIX-1:0] fix_ovf,
  output logic [NUM_GP-1:0]  gp_run,
  output logic [NUM_FIX-1:0] fix_run,
  output logic [NUM_FIX-1:0] fix_os_cnt,
  output logic [NUM_FIX-1:0] fix_usr_cnt,
  output logic [REG_W-1:0]   ovf_vec,
  output logic [REG_W-1:0]   ie_vec
);
  logic [REG_W-1:0] ovf_w;
  logic [REG_W-1:0] ie_w;

  always_comb begin
    ovf_w = '0;
    ie_w  = '0;
    for (int n = 0; n < NUM_GP; n++) begin
      ovf_w[n] = gp_ovf[n];
      ie_w[n]  = gp_int_en[n];
    end
    for (int k = 0; k < NUM_FIX; k++) begin
      ovf_w[FIX_BASE+k] = fix_ovf[k];
      ie_w[FIX_BASE+k]  = fctl_q[4*k+3];
    end
  end

  assign ovf_vec = ovf_w;
  assign ie_vec  = ie_w;

  for (genvar n = 0; n < NUM_GP; n++) begin : g_gp
    assign gp_run[n] = gen_q[n] & gp_local_en[n];
  end

  for (genvar k = 0; k < NUM_FIX; k++) begin : g_fix
    logic glb;
    logic os_b;
    logic usr_b;
    assign glb            = gen_q[FIX_BASE+k];
    assign os_b           = fctl_q[4*k];
    assign usr_b          = fctl_q[4*k+1];
    assign fix_os_cnt[k]  = glb & os_b;
    assign fix_usr_cnt[k] = glb & usr_b;
    assign fix_run[k]     = glb & (os_b | usr_b);
  end
endmodule

// File: rtl/pmu_gc_status.sv
module pmu_gc_status
  import pmu_gc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] ovf_vec,
  input  logic [REG_W-1:0] ie_vec,
  input  logic [REG_W-1:0] clr_vec,
  output logic [REG_W-1:0] status_q,
  output logic             irq
);
  logic [REG_W-1:0] status_d;
  logic             st_ld;
  logic             irq_d;

  always_comb begin
    // A set in the same cycle as a clear wins.
    status_d = (status_q & ~clr_vec) | ovf_vec;
    st_ld    = (|ovf_vec) | (|clr_vec);
    irq_d    = |(ovf_vec & ie_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     status_q <= '0;
    else if (st_ld) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/pmu_global_ctl.sv
module pmu_global_ctl
  import pmu_gc_pkg::*;
#(
  parameter int NUM_GP  = 4,   // up to 32
  parameter int NUM_FIX = 3    // up to 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reg_addr,
  input  logic               reg_we,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  input  logic [NUM_GP-1:0]  gp_local_en,
  input  logic [NUM_GP-1:0]  gp_int_en,
  input  logic [NUM_GP-1:0]  gp_ovf,
  input  logic [NUM_FIX-1:0] fix_ovf,
  output logic [NUM_GP-1:0]  gp_run,
  output logic [NUM_FIX-1:0] fix_run,
  output logic [NUM_FIX-1:0] fix_os_cnt,
  output logic [NUM_FIX-1:0] fix_usr_cnt,
  output logic               irq
);
  localparam int FCTL_W = 4 * NUM_FIX;

  logic [FCTL_W-1:0] fctl_q;
  logic [REG_W-1:0]  gen_q;
  logic [REG_W-1:0]  clr_vec;
  logic [REG_W-1:0]  ovf_vec;
  logic [REG_W-1:0]  ie_vec;
  logic [REG_W-1:0]  status_q;

  pmu_gc_regs #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .fctl_q(fctl_q), .gen_q(gen_q), .clr_vec(clr_vec)
  );

  pmu_gc_gate #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX)) u_gate (
    .gen_q(gen_q), .fctl_q(fctl_q), .gp_local_en(gp_local_en),
    .gp_int_en(gp_int_en), .gp_ovf(gp_ovf), .fix_ovf(fix_ovf),
    .gp_run(gp_run), .fix_run(fix_run), .fix_os_cnt(fix_os_cnt),
    .fix_usr_cnt(fix_usr_cnt), .ovf_vec(ovf_vec), .ie_vec(ie_vec)
  );

  pmu_gc_status u_status (
    .clk(clk), .rst_n(rst_n), .ovf_vec(ovf_vec), .ie_vec(ie_vec),
    .clr_vec(clr_vec), .status_q(status_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_FIX_CTL: reg_rdata[FCTL_W-1:0] = fctl_q;
      A_GLB_EN:  reg_rdata = gen_q;
      A_STATUS:  reg_rdata = status_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmu_global_ctl_chk.sv
module pmu_global_ctl_chk
  import pmu_gc_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_addr,
  input logic              reg_we,
  input logic [63:0]       reg_wdata,
  input logic [63:0]       reg_rdata,
  input logic [NUM_GP-1:0] gp_local_en,
  input logic [NUM_GP-1:0] gp_run,
  input logic [63:0]       ovf_vec,
  input logic [63:0]       ie_vec,
  input logic [63:0]       status_q,
  input logic              irq
);
  localparam logic [63:0] MASK = impl_mask(NUM_GP, NUM_FIX);

  logic        past_ok;
  logic [63:0] clr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign clr_w = (reg_we && reg_addr == A_CLEAR) ? reg_wdata : 64'd0;

  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_GLB_EN || reg_addr == A_STATUS) |-> ((reg_rdata & ~MASK) == 64'd0));

  assert_gp_run_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((gp_run & ~gp_local_en) == '0));

  assert_ovf_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((status_q & $past(ovf_vec)) == $past(ovf_vec)));

  assert_clear_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CLEAR) |-> (reg_rdata == 64'd0));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (($past(status_q) & ~$past(clr_w) & ~status_q) == 64'd0));

  assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (irq == (|($past(ovf_vec) & $past(ie_vec)))));
endmodule

bind pmu_global_ctl pmu_global_ctl_chk #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gp_local_en(gp_local_en),
  .gp_run(gp_run), .ovf_vec(ovf_vec), .ie_vec(ie_vec), .status_q(status_q),
  .irq(irq)
);

// File: tb/pmu_global_ctl_test.sv
module pmu_global_ctl_test;
  localparam int CLK_PERIOD = 20;
  localparam int NG = 4;
  localparam int NF = 3;
  localparam logic [63:0] MASK = 64'h0000_0007_0000_000F;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic          reg_we = 1'b0;
  logic [63:0]   reg_wdata = 64'd0;
  logic [63:0]   reg_rdata;
  logic [NG-1:0] gp_local_en = '0, gp_int_en = '0, gp_ovf = '0, gp_run;
  logic [NF-1:0] fix_ovf = '0, fix_run, fix_os_cnt, fix_usr_cnt;
  logic          irq;

  pmu_global_ctl #(.NUM_GP(NG), .NUM_FIX(NF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gp_local_en(gp_local_en),
    .gp_int_en(gp_int_en), .gp_ovf(gp_ovf), .fix_ovf(fix_ovf), .gp_run(gp_run),
    .fix_run(fix_run), .fix_os_cnt(fix_os_cnt), .fix_usr_cnt(fix_usr_cnt), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  logic [11:0] m_fctl = '0;
  logic [63:0] m_en = '0, m_st = '0;
  logic        m_irq = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return {52'd0, m_fctl};
      2'd1:    return m_en;
      2'd2:    return m_st;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [NF-1:0] fbit(input int b);
    logic [NF-1:0] v;
    for (int k = 0; k < NF; k++) v[k] = m_fctl[4*k+b];
    return v;
  endfunction

  // One clock with the given stimulus; model updated from the requirements.
  task automatic step(input logic we, input logic [1:0] a, input logic [63:0] d,
                      input logic [NG-1:0] lie, input logic [NG-1:0] gie,
                      input logic [NG-1:0] gov, input logic [NF-1:0] fov);
    logic [63:0] ovfv, iev, clr;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d;
    gp_local_en = lie; gp_int_en = gie; gp_ovf = gov; fix_ovf = fov;
    ovfv = {29'd0, fov, 28'd0, gov};
    iev  = {29'd0, fbit(3), 28'd0, gie};
    clr  = (we && a == 2'd3) ? (d & MASK) : 64'd0;
    @(posedge clk);
    m_irq = |(ovfv & iev);
    m_st  = (m_st & ~clr) | ovfv;
    if (we && a == 2'd0) m_fctl = d[11:0];
    if (we && a == 2'd1) m_en = d & MASK;
    #1;
    reg_we = 1'b0; gp_ovf = '0; fix_ovf = '0;
  endtask

  task automatic check_all(input string ctx);
    check({ctx, " R8 irq"}, {63'd0, irq}, {63'd0, m_irq});
    check({ctx, " R4 gp_run"}, {60'd0, gp_run}, {60'd0, m_en[NG-1:0] & gp_local_en});
    check({ctx, " R4 fix_run"}, {61'd0, fix_run}, {61'd0, m_en[34:32] & (fbit(0) | fbit(1))});
    check({ctx, " R3 os"}, {61'd0, fix_os_cnt}, {61'd0, m_en[34:32] & fbit(0)});
    check({ctx, " R3 usr"}, {61'd0, fix_usr_cnt}, {61'd0, m_en[34:32] & fbit(1)});
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a);
      #1;
      check($sformatf("%s R5/R6 read a%0d", ctx, a), reg_rdata, exp_read(2'(a)));
    end
  endtask

  bit finished = 0;
  initial begin
    for (int c = 0; c < 100000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check_all("R1 reset");

    // R2 unimplemented enable bits
    step(1, 2'd1, 64'hFFFF_FFFF_FFFF_FFFF, '1, '0, '0, '0);
    check_all("R2 enable all ones");
    // R3 field layout, OS on counter 0, user on 1, both plus irq on 2
    step(1, 2'd0, 64'hFFFF_FFFF_FFFF_FB21, '1, '0, '0, '0);
    check_all("R3 fields");
    // R8 disabled gp irq: status only
    step(0, 2'd0, 64'd0, '1, 4'b0000, 4'b0010, 3'b000);
    check_all("R8 no irq");
    // R8 fixed counter 2 with irq enabled
    step(0, 2'd0, 64'd0, '1, 4'b0000, 4'b0000, 3'b100);
    check_all("R8 fixed irq");
    // R8 single pulse
    step(0, 2'd0, 64'd0, '1, 4'b0000, 4'b0000, 3'b000);
    check_all("R8 pulse ends");
    // R9 write to status ignored
    step(1, 2'd2, 64'd0, '1, '0, '0, '0);
    check_all("R9 status write");
    // R6 clear with zero data changes nothing
    step(1, 2'd3, 64'd0, '1, '0, '0, '0);
    check_all("R6 clear zero");
    // R7 clear and overflow on the same bit
    step(1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, '1, 4'b0010, 4'b0010, 3'b000);
    check_all("R7 collision");
    check("R7 bit1 held", {63'd0, m_st[1]}, 64'd1);
    // R6 clear all
    step(1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, '1, '0, '0, '0);
    check_all("R6 clear all");

    // random phase
    for (int i = 0; i < 400; i++) begin
      logic [63:0] d;
      logic [1:0]  a;
      d = {$urandom(), $urandom()};
      a = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 2) != 0), a, d, 4'($urandom()), 4'($urandom()),
           ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'd0,
           ($urandom_range(0, 3) == 0) ? 3'($urandom()) : 3'd0);
      check_all($sformatf("rand%0d", i));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule